// File: doc/BRIEF.md
# Multi-mode USART baud clock generator

This block produces the timing strobes for a serial transmitter and receiver that can run in four clocking modes: plain asynchronous, asynchronous at double speed, synchronous with the block driving the serial clock pin, and synchronous with an external device driving that pin. A 12-bit rate divisor feeds a down-counter running on the system clock. Each time the counter reaches zero it gives one base strobe, so the base rate is fsys/(divisor+1). The receiver uses that strobe as it is. The transmitter's bit strobe is the base strobe divided by 16, 8 or 2, depending on the mode.

Software writes the divisor as two bytes. The upper nibble is held in a buffer and the whole 12-bit value takes effect on the lower-byte write, which also restarts the counter. When the external device drives the serial clock, that input is synchronized and each rising edge yields one bit strobe; the internal divider is then not used. Shifting, framing and data recovery sit in neighbouring blocks.

Top module: `usart_baud_gen`

## Requirements
- R1: A strobe on `div_hi_wr` stores `wr_data[3:0]` in a buffer and does not change the rate. A strobe on `div_lo_wr` sets the divisor to {buffer, `wr_data[7:0]`}.
- R2: A `div_lo_wr` strobe reloads the down-counter with the new divisor D. The first `rx_tick` after the write appears D cycles after the clock edge that took the write.
- R3: Outside the external-clock mode, `rx_tick` is a one-cycle strobe every D+1 cycles. With D=0 it is high on every cycle.
- R4: In plain asynchronous mode (`sync_mode`=0, `dbl_speed`=0), `tx_tick` repeats every 16*(D+1) cycles.
- R5: In double-speed asynchronous mode (`sync_mode`=0, `dbl_speed`=1), `tx_tick` repeats every 8*(D+1) cycles. D=207 gives 1664 cycles (9600 bit/s at 16 MHz) and D=16 gives 136 cycles (about 115.2 kbit/s).
- R6: In clock-driving synchronous mode (`sync_mode`=1, `clk_is_out`=1), `tx_tick` repeats every 2*(D+1) cycles whatever `dbl_speed` is. `xclk_oe` is 1, and `xclk_out` is high for D+1 of every 2*(D+1) cycles and falls right after each `tx_tick`.
- R7: In clock-following synchronous mode (`sync_mode`=1, `clk_is_out`=0), a rising edge on `xclk_in` yields exactly one one-cycle `tx_tick`. It is visible in the cycle after the second rising system clock edge that samples `xclk_in` high. `rx_tick` equals `tx_tick`, and no strobe appears while `xclk_in` is steady.
- R8: After reset the divisor is 0 and the mode is plain asynchronous. `xclk_out` and `xclk_oe` are 0, `rx_tick` is high on every cycle, and `tx_tick` repeats every 16 cycles.
- R9: A change of the mode inputs clears the transmit prescaler. When the change comes in the same cycle as a `div_lo_wr` strobe, the first `tx_tick` appears N*(D+1)-1 cycles after that write edge, where N is the new mode's ratio.
- R10: Outside clock-driving mode, `xclk_out` and `xclk_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_lo_wr | input | 1 | Strobe: write the lower divisor byte and restart the counter |
| div_hi_wr | input | 1 | Strobe: write the upper divisor nibble into the buffer |
| wr_data | input | 8 | Write data for both divisor strobes |
| sync_mode | input | 1 | 1 selects synchronous clocking |
| dbl_speed | input | 1 | 1 selects double speed in asynchronous mode |
| clk_is_out | input | 1 | In synchronous mode, 1 drives the serial clock and 0 follows it |
| xclk_in | input | 1 | External serial clock input |
| rx_tick | output | 1 | Receiver sample strobe |
| tx_tick | output | 1 | Transmitter bit strobe |
| xclk_out | output | 1 | Serial clock value to drive |
| xclk_oe | output | 1 | Output enable for the serial clock pin |

## Verification
A wrong count in the divisor or the down-counter changes the `rx_tick` spacing at once, within one base period. A wrong prescaler state or ratio first shows as a `tx_tick` interval that differs from N*(D+1). A prescaler that is not cleared on a mode change shows up in the first interval after the switch. A synchronizer fault gives a strobe that comes one cycle early or late, or a doubled pulse after an `xclk_in` rise. A slip in the high-byte buffer only appears at the next lower-byte write, as a period that is off by a multiple of 256 cycles.

// File: rtl/usart_bg_pkg.sv
package usart_bg_pkg;

  typedef enum logic [1:0] {
    BG_NORM = 2'd0,
    BG_DBL  = 2'd1,
    BG_MST  = 2'd2,
    BG_SLV  = 2'd3
  } bg_mode_e;

  // Map the three select inputs onto one mode; dbl only matters when async.
  function automatic bg_mode_e decode_mode(input logic sync, input logic dbl,
                                           input logic drive);
    if (sync) return drive ? BG_MST : BG_SLV;
    return dbl ? BG_DBL : BG_NORM;
  endfunction

  // Base strobes per transmit bit in each mode.
  function automatic logic [4:0] presc_ratio(input bg_mode_e m);
    case (m)
      BG_NORM: return 5'd16;
      BG_DBL:  return 5'd8;
      BG_MST:  return 5'd2;
      default: return 5'd1;
    endcase
  endfunction

endpackage

// File: rtl/bg_divisor_reg.sv
module bg_divisor_reg #(
  parameter int DIV_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [DIV_W-1:0]  divisor,
  output logic [DIV_W-1:0]  load_val,
  output logic              load
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [HI_W-1:0] hi_buf;

  assign load_val = {hi_buf, wr_data};
  assign load     = lo_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_buf  <= '0;
      divisor <= '0;
    end else begin
      if (hi_wr) hi_buf <= wr_data[HI_W-1:0];
      if (lo_wr) divisor <= load_val;
    end
  end

  // R1: an upper-nibble write alone leaves the active divisor untouched
  a_r1_hi_only_buffers: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !lo_wr) |=> $stable(divisor));

endmodule

// File: rtl/bg_down_counter.sv
module bg_down_counter #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [DIV_W-1:0] load_val,
  input  logic             load,
  output logic             base_tick
);
  logic [DIV_W-1:0] cnt;
  logic             at_zero;

  assign at_zero   = (cnt == '0);
  assign base_tick = at_zero && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (load)    cnt <= load_val;
    else if (at_zero) cnt <= divisor;
    else              cnt <= cnt - 1'b1;
  end

  // R2: a lower-byte write restarts the count from the new value
  a_r2_reload_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

  // R3: with a nonzero divisor two base strobes never touch
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && divisor != '0) |=> !base_tick);

endmodule

// File: rtl/bg_tx_prescaler.sv
module bg_tx_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic             clr,
  input  logic [PRE_W-1:0] last_idx,
  output logic [PRE_W-1:0] pcnt,
  output logic             wrap
);
  assign wrap = base_tick && !clr && (pcnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pcnt <= '0;
    else if (clr)       pcnt <= '0;
    else if (wrap)      pcnt <= '0;
    else if (base_tick) pcnt <= pcnt + 1'b1;
  end

  // R4: the prescale count never passes the selected ratio
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= last_idx);

  // R9: a mode change leaves the prescaler at its start
  a_r9_clear_on_mode: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pcnt == '0));

endmodule

// File: rtl/bg_edge_sync.sv
module bg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] && !sh[STAGES];

  // R7: one strobe per detected edge
  a_r7_one_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/usart_baud_gen.sv
module usart_baud_gen
  import usart_bg_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_lo_wr,
  input  logic              div_hi_wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              sync_mode,
  input  logic              dbl_speed,
  input  logic              clk_is_out,
  input  logic              xclk_in,
  output logic              rx_tick,
  output logic              tx_tick,
  output logic              xclk_out,
  output logic              xclk_oe
);
  localparam int PRE_W = 4;

  logic [DIV_W-1:0] divisor, load_val;
  logic             load, base_tick, wrap, ext_rise;
  logic [PRE_W-1:0] pcnt, last_idx;
  logic [4:0]       ratio;
  bg_mode_e         mode_now, mode_q;
  logic             mode_chg, is_slave, is_master;

  assign mode_now  = decode_mode(sync_mode, dbl_speed, clk_is_out);
  assign mode_chg  = (mode_now != mode_q);
  assign is_slave  = (mode_q == BG_SLV);
  assign is_master = (mode_q == BG_MST);
  assign ratio     = presc_ratio(mode_q);
  assign last_idx  = PRE_W'(ratio - 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= BG_NORM;
    else        mode_q <= mode_now;
  end

  bg_divisor_reg #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .lo_wr(div_lo_wr), .hi_wr(div_hi_wr),
    .wr_data(wr_data), .divisor(divisor), .load_val(load_val), .load(load)
  );

  bg_down_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .load_val(load_val),
    .load(load), .base_tick(base_tick)
  );

  bg_tx_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .clr(mode_chg),
    .last_idx(last_idx), .pcnt(pcnt), .wrap(wrap)
  );

  bg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(xclk_in), .rise(ext_rise)
  );

  assign tx_tick  = is_slave ? (ext_rise && !mode_chg) : wrap;
  assign rx_tick  = is_slave ? (ext_rise && !mode_chg) : base_tick;
  assign xclk_oe  = is_master;
  assign xclk_out = is_master && pcnt[0];

  // R6: the driven serial clock drops right after each bit strobe
  a_r6_xclk_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick && xclk_oe && !mode_chg) |=> !xclk_out);

  // R7: in clock-following mode a bit strobe is a single cycle
  a_r7_slave_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick && is_slave) |=> !tx_tick);

  // R10: the pin value is low whenever the pin is not driven
  a_r10_quiet_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && !mode_chg) |=> (!xclk_out || xclk_oe));

endmodule

// File: tb/sim_usart_baud_gen.sv
module sim_usart_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_lo_wr = 1'b0, div_hi_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       sync_mode = 1'b0, dbl_speed = 1'b0, clk_is_out = 1'b0;
  logic       xclk_in = 1'b0;
  logic       rx_tick, tx_tick, xclk_out, xclk_oe;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int c0, c1, c2;
  int exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usart_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .div_lo_wr(div_lo_wr), .div_hi_wr(div_hi_wr),
    .wr_data(wr_data), .sync_mode(sync_mode), .dbl_speed(dbl_speed),
    .clk_is_out(clk_is_out), .xclk_in(xclk_in), .rx_tick(rx_tick),
    .tx_tick(tx_tick), .xclk_out(xclk_out), .xclk_oe(xclk_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Wait (from the current negedge) for a strobe; returns cycle stamp.
  task automatic wait_sig(input bit use_tx, input bit advance, output int stamp);
    int lim = 0;
    if (advance) @(negedge clk);
    while (!(use_tx ? tx_tick : rx_tick) && lim < 20000) begin
      @(negedge clk);
      lim++;
    end
    if (lim >= 20000) check(1'b0, "timeout", lim, 0);
    stamp = cyc;
  endtask

  // Driver: a one-cycle write with new mode inputs; returns the stamp after the edge.
  task automatic write_cfg(input bit lo, input bit hi, input logic [7:0] d,
                           input bit s, input bit db, input bit dir, output int stamp);
    @(negedge clk);
    div_lo_wr = lo; div_hi_wr = hi; wr_data = d;
    sync_mode = s; dbl_speed = db; clk_is_out = dir;
    @(negedge clk);
    div_lo_wr = 1'b0; div_hi_wr = 1'b0;
    stamp = cyc;
  endtask

  // Driver side of the scoreboard.
  task automatic expect_gaps(input int n, input int gap);
    for (int i = 0; i < n; i++) exp_q.push_back(gap);
  endtask

  // Monitor side: measures successive bit strobe gaps against the queue.
  task automatic drain(input string tag);
    int a, b;
    wait_sig(1'b1, 1'b0, a);
    while (exp_q.size() > 0) begin
      int e;
      e = exp_q.pop_front();
      wait_sig(1'b1, 1'b1, b);
      check(b - a == e, tag, b - a, e);
      a = b;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hi_cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state, R3 with D=0
    check(xclk_out == 1'b0, "R8 xclk_out", xclk_out, 0);
    check(xclk_oe == 1'b0, "R8 xclk_oe", xclk_oe, 0);
    for (int i = 0; i < 3; i++) begin
      check(rx_tick == 1'b1, "R8 R3 rx every cycle", rx_tick, 1);
      @(negedge clk);
    end
    expect_gaps(2, 16);
    drain("R8 R4 tx gap at D=0");

    // R2 reload, R3 rx period, R4 normal async
    write_cfg(1'b0, 1'b1, 8'h00, 0, 0, 0, c0);
    write_cfg(1'b1, 1'b0, 8'd3, 0, 0, 0, c0);
    wait_sig(1'b0, 1'b0, c1);
    check(c1 - c0 == 3, "R2 first rx after write", c1 - c0, 3);
    wait_sig(1'b0, 1'b1, c2);
    check(c2 - c1 == 4, "R3 rx period D=3", c2 - c1, 4);
    expect_gaps(3, 64);
    drain("R4 normal tx gap D=3");

    // R1: nibble buffered, no effect until lower write
    write_cfg(1'b0, 1'b1, 8'hF1, 0, 0, 0, c0);
    wait_sig(1'b0, 1'b0, c1);
    wait_sig(1'b0, 1'b1, c2);
    check(c2 - c1 == 4, "R1 hi write alone keeps rate", c2 - c1, 4);
    write_cfg(1'b1, 1'b0, 8'h02, 0, 0, 0, c0);
    wait_sig(1'b0, 1'b0, c1);
    check(c1 - c0 == 258, "R1 R2 combined divisor reload", c1 - c0, 258);
    wait_sig(1'b0, 1'b1, c2);
    check(c2 - c1 == 259, "R1 R3 rx period 0x102", c2 - c1, 259);

    // R9 + R5: switch to double speed with D=207 in one write
    write_cfg(1'b0, 1'b1, 8'h00, 0, 0, 0, c0);
    write_cfg(1'b1, 1'b0, 8'd207, 0, 1, 0, c0);
    wait_sig(1'b1, 1'b0, c1);
    check(c1 - c0 == 1663, "R9 first tx after switch to dbl", c1 - c0, 1663);
    expect_gaps(2, 1664);
    drain("R5 9600 bit/s gap");
    write_cfg(1'b1, 1'b0, 8'd16, 0, 1, 0, c0);
    expect_gaps(3, 136);
    drain("R5 115.2k gap");

    // R6 + R9: clock-driving synchronous, D=4
    write_cfg(1'b1, 1'b0, 8'd4, 1, 0, 1, c0);
    wait_sig(1'b1, 1'b0, c1);
    check(c1 - c0 == 9, "R9 first tx after switch to master", c1 - c0, 9);
    check(xclk_oe == 1'b1, "R6 xclk_oe in master", xclk_oe, 1);
    hi_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (xclk_out) hi_cnt++;
    end
    check(hi_cnt == 5, "R6 xclk high cycles per period", hi_cnt, 5);
    check(tx_tick == 1'b1, "R6 tx at end of xclk period", tx_tick, 1);
    @(negedge clk);
    check(xclk_out == 1'b0, "R6 xclk low after tx", xclk_out, 0);
    expect_gaps(2, 10);
    drain("R6 master tx gap");
    @(negedge clk) dbl_speed = 1'b1;
    expect_gaps(2, 10);
    drain("R6 dbl ignored in master");

    // R7 + R10: clock-following synchronous
    @(negedge clk) begin sync_mode = 1'b1; clk_is_out = 1'b0; dbl_speed = 1'b0; end
    hi_cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tx_tick || rx_tick) hi_cnt++;
    end
    check(hi_cnt == 0, "R7 no strobe on steady xclk_in", hi_cnt, 0);
    check(xclk_oe == 1'b0, "R10 oe low in slave", xclk_oe, 0);
    check(xclk_out == 1'b0, "R10 xclk_out low in slave", xclk_out, 0);
    for (int k = 0; k < 2; k++) begin
      xclk_in = 1'b1;
      @(negedge clk);
      check(tx_tick == 1'b0, "R7 not after one sample", tx_tick, 0);
      @(negedge clk);
      check(tx_tick == 1'b1, "R7 strobe after second sample", tx_tick, 1);
      check(rx_tick == tx_tick, "R7 rx equals tx", rx_tick, tx_tick);
      @(negedge clk);
      check(tx_tick == 1'b0, "R7 strobe lasts one cycle", tx_tick, 0);
      repeat (3) @(negedge clk);
      xclk_in = 1'b0;
      hi_cnt = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (tx_tick) hi_cnt++;
      end
      check(hi_cnt == 0, "R7 no strobe on falling edge", hi_cnt, 0);
    end

    // R10 back in asynchronous mode
    @(negedge clk) sync_mode = 1'b0;
    repeat (3) @(negedge clk);
    check(xclk_out == 1'b0 && xclk_oe == 1'b0, "R10 pin quiet in async",
          {xclk_out, xclk_oe}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule